// File: doc/BRIEF.md
# Tuner Control I2C Register Slave

This block is the serial configuration port of a tuner control chip. A two-wire bus master reaches twelve writable configuration bytes and two read-only status bytes through it. The raw bus clock and data lines are sampled by a much faster system clock, at least sixteen times the 400 kHz bus rate. They pass through two-flop synchronizers before START, STOP and clock edges are recognized. The block answers one 7-bit device address. The low address bit comes from a board-level select pin, so two tuners can share one bus.

Every transaction starts with the device address and the write bit, followed by a register-pointer byte. In a write, the data bytes that follow land in consecutive registers. In a read, the master issues a repeated START and the address with the read bit, and the block then streams consecutive registers until the master declines a byte. The configuration bytes appear as parallel registered outputs. The status bytes are assembled from live status inputs and a power-on flag, which stays set until a STOP closes a transaction that read the first status byte. Writing the divider low byte produces a one-cycle pulse for downstream synthesizer logic.

Top module: `tuner_i2c_regs`

## Requirements
- R1: The block acknowledges only the address `110000A`, where A is `addr_sel_i`. This gives write/read bytes 0xC0/0xC1 with the pin low and 0xC2/0xC3 with it high. Any other address is not acknowledged and the rest of that transaction is ignored.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START inside a transaction restarts the address phase, and the transaction still performs its writes.
- R3: In a write, the first byte after the address sets the register pointer. Each following data byte is stored at the pointer, and the pointer then advances by one, until STOP.
- R4: After a repeated START with the read bit, the block sends the pointed register MSB first. It advances to the next register each time the master acknowledges, and releases SDA once the master does not acknowledge.
- R5: The slave acknowledges a matching address, the pointer byte and every written data byte by pulling SDA low (`sda_oe_o`=1) through the ninth clock. The slave changes `sda_oe_o` only while SCL is low.
- R6: After reset the configuration bytes 0x00..0x0B hold 0x03, 0xB6, 0x00, 0x00, 0x00, 0x04, 0xC0, 0xCC, 0x4B, 0x00, 0x00 and 0x00.
- R7: Register 0x0C reads as {power-on flag, `vas_ok_i`, `vas_idle_i`, `pll_lock_i`, 4'b0000} (bit 7 down to bit 0). Register 0x0D reads as {`vco_band_i`[4:0], `adc_code_i`[2:0]}.
- R8: A data byte written to 0x0C or any higher pointer is acknowledged but changes no register. A read of any pointer above 0x0D returns 0x00.
- R9: The power-on flag (bit 7 of 0x0C) is 1 after reset. It clears at the STOP that ends a transaction in which 0x0C was sent. A STOP after a transaction that did not send 0x0C leaves it set.
- R10: Each data byte written to register 0x01 raises `div_lo_wr_o` for exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel_i | input | 1 | Device address select, supplies address bit 0 |
| vas_ok_i | input | 1 | Oscillator band search succeeded |
| vas_idle_i | input | 1 | Oscillator band search not running |
| pll_lock_i | input | 1 | Synthesizer lock indication |
| vco_band_i | input | 5 | Oscillator band currently selected |
| adc_code_i | input | 3 | Tuning-voltage comparator code |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| cfg_regs_o | output | 96 | Configuration bytes, byte i at bits [8i+7:8i] |
| div_lo_wr_o | output | 1 | One-cycle pulse on a write of register 0x01 |

## Verification
The hardest condition to reach from the pins is the clearing of the power-on flag. It needs a read burst that actually sends 0x0C, followed by a STOP. A read that sends only 0x0D, or a burst the master ends early, must leave the flag set. The directed sequence first reads 0x0D alone, then reads 0x0C, then reads it again to see the cleared bit. Seeded random bursts then cross 0x0C from both sides with random lengths, and a bench model tracks which bytes the master actually received.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } bkind_t;

  // Power-up contents of the writable configuration bytes.
  function automatic logic [BYTE_W-1:0] cfg_reset_value(input int unsigned idx);
    case (idx)
      0:       return 8'h03;  // divider high byte
      1:       return 8'hB6;  // divider low byte
      5:       return 8'h04;  // reference divide by four
      6:       return 8'hC0;  // divide-by-4 LO, pump current from band search
      7:       return 8'hCC;  // band start 25, search enabled
      8:       return 8'h4B;  // filter corner code
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic prev_o
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '1;
      prev_o <= 1'b1;
    end else begin
      chain  <= {chain[STAGES-2:0], line_i};
      prev_o <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import tcfg_pkg::*;
#(
  parameter logic [5:0] DEV_BASE = 6'b110000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              scl_prv,
  input  logic              sda_lvl,
  input  logic              sda_prv,
  input  logic              addr_sel_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic [BYTE_W-1:0] rd_addr_o,
  output logic              rd_take_o,
  output logic [BYTE_W-1:0] rd_take_addr_o,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              stop_o
);

  logic start_det, stop_det, scl_rise, scl_fall;
  assign start_det = scl_lvl & scl_prv & sda_prv & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prv & ~sda_prv & sda_lvl;
  assign scl_rise  = scl_lvl & ~scl_prv;
  assign scl_fall  = ~scl_lvl & scl_prv;

  phase_t            phase;
  bkind_t            kind;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] ptr;
  logic              rnw;
  logic              more;

  assign rd_addr_o = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase          <= PH_IDLE;
      kind           <= BK_ADDR;
      bit_cnt        <= '0;
      shreg          <= '0;
      ptr            <= '0;
      rnw            <= 1'b0;
      more           <= 1'b0;
      sda_oe_o       <= 1'b0;
      wr_en_o        <= 1'b0;
      wr_addr_o      <= '0;
      wr_data_o      <= '0;
      rd_take_o      <= 1'b0;
      rd_take_addr_o <= '0;
      stop_o         <= 1'b0;
    end else begin
      wr_en_o   <= 1'b0;
      rd_take_o <= 1'b0;
      stop_o    <= stop_det;
      if (stop_det) begin
        phase    <= PH_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_det) begin
        phase    <= PH_RX;
        kind     <= BK_ADDR;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        case (phase)
          PH_RX: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              case (kind)
                BK_ADDR: begin
                  if (shreg[7:1] == {DEV_BASE, addr_sel_i}) begin
                    rnw      <= shreg[0];
                    sda_oe_o <= 1'b1;
                    phase    <= PH_RX_ACK;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                BK_PTR: begin
                  ptr      <= shreg;
                  sda_oe_o <= 1'b1;
                  phase    <= PH_RX_ACK;
                end
                default: begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr;
                  wr_data_o <= shreg;
                  ptr       <= ptr + 8'd1;
                  sda_oe_o  <= 1'b1;
                  phase     <= PH_RX_ACK;
                end
              endcase
            end
          end
          PH_RX_ACK: begin
            if (scl_fall) begin
              if (kind == BK_ADDR && rnw) begin
                shreg          <= {rd_byte_i[BYTE_W-2:0], 1'b0};
                sda_oe_o       <= ~rd_byte_i[BYTE_W-1];
                rd_take_o      <= 1'b1;
                rd_take_addr_o <= ptr;
                ptr            <= ptr + 8'd1;
                bit_cnt        <= '0;
                phase          <= PH_TX;
              end else begin
                sda_oe_o <= 1'b0;
                kind     <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
                phase    <= PH_RX;
              end
            end
          end
          PH_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe_o <= 1'b0;
                bit_cnt  <= '0;
                phase    <= PH_TX_ACK;
              end else begin
                sda_oe_o <= ~shreg[BYTE_W-1];
                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
              end
            end
          end
          PH_TX_ACK: begin
            if (scl_rise) begin
              more <= ~sda_lvl;
            end else if (scl_fall) begin
              if (more) begin
                shreg          <= {rd_byte_i[BYTE_W-2:0], 1'b0};
                sda_oe_o       <= ~rd_byte_i[BYTE_W-1];
                rd_take_o      <= 1'b1;
                rd_take_addr_o <= ptr;
                ptr            <= ptr + 8'd1;
                bit_cnt        <= '0;
                phase          <= PH_TX;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import tcfg_pkg::*;
#(
  parameter int unsigned NUM_WR     = 12,
  parameter int unsigned DIV_LO_IDX = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [BYTE_W-1:0]             wr_addr,
  input  logic [BYTE_W-1:0]             wr_data,
  input  logic [BYTE_W-1:0]             rd_addr,
  input  logic                          rd_take,
  input  logic [BYTE_W-1:0]             rd_take_addr,
  input  logic                          stop_i,
  input  logic                          vas_ok_i,
  input  logic                          vas_idle_i,
  input  logic                          pll_lock_i,
  input  logic [4:0]                    vco_band_i,
  input  logic [2:0]                    adc_code_i,
  output logic [NUM_WR-1:0][BYTE_W-1:0] cfg_o,
  output logic [BYTE_W-1:0]             rd_data_o,
  output logic                          div_lo_wr_o,
  output logic                          por_o
);

  localparam int unsigned     IDX_W    = $clog2(NUM_WR);
  localparam logic [BYTE_W-1:0] ST1_ADDR = BYTE_W'(NUM_WR);
  localparam logic [BYTE_W-1:0] ST2_ADDR = BYTE_W'(NUM_WR + 1);

  for (genvar i = 0; i < NUM_WR; i++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                   q <= cfg_reset_value(i);
      else if (wr_en && wr_addr == BYTE_W'(i))   q <= wr_data;
    end
    assign cfg_o[i] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) div_lo_wr_o <= 1'b0;
    else     div_lo_wr_o <= wr_en && (wr_addr == BYTE_W'(DIV_LO_IDX));
  end

  logic st1_sent;
  always_ff @(posedge clk) begin
    if (rst) begin
      por_o    <= 1'b1;
      st1_sent <= 1'b0;
    end else if (stop_i) begin
      if (st1_sent) por_o <= 1'b0;
      st1_sent <= 1'b0;
    end else if (rd_take && rd_take_addr == ST1_ADDR) begin
      st1_sent <= 1'b1;
    end
  end

  always_comb begin
    if (rd_addr < ST1_ADDR)       rd_data_o = cfg_o[rd_addr[IDX_W-1:0]];
    else if (rd_addr == ST1_ADDR) rd_data_o = {por_o, vas_ok_i, vas_idle_i, pll_lock_i, 4'b0000};
    else if (rd_addr == ST2_ADDR) rd_data_o = {vco_band_i, adc_code_i};
    else                          rd_data_o = '0;
  end

endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
  import tcfg_pkg::*;
#(
  parameter int unsigned NUM_WR      = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [5:0]  DEV_BASE    = 6'b110000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          scl_i,
  input  logic                          sda_i,
  input  logic                          addr_sel_i,
  input  logic                          vas_ok_i,
  input  logic                          vas_idle_i,
  input  logic                          pll_lock_i,
  input  logic [4:0]                    vco_band_i,
  input  logic [2:0]                    adc_code_i,
  output logic                          sda_oe_o,
  output logic [NUM_WR-1:0][BYTE_W-1:0] cfg_regs_o,
  output logic                          div_lo_wr_o
);

  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw_l, lvl_l, prv_l;
  assign raw_l = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .line_i  (raw_l[g]),
      .level_o (lvl_l[g]),
      .prev_o  (prv_l[g])
    );
  end

  logic              wr_en, rd_take, stop_pulse, por_flag;
  logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_take_addr, rd_byte;

  i2c_slave_fsm #(.DEV_BASE(DEV_BASE)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .scl_lvl        (lvl_l[1]),
    .scl_prv        (prv_l[1]),
    .sda_lvl        (lvl_l[0]),
    .sda_prv        (prv_l[0]),
    .addr_sel_i     (addr_sel_i),
    .rd_byte_i      (rd_byte),
    .rd_addr_o      (rd_addr),
    .rd_take_o      (rd_take),
    .rd_take_addr_o (rd_take_addr),
    .sda_oe_o       (sda_oe_o),
    .wr_en_o        (wr_en),
    .wr_addr_o      (wr_addr),
    .wr_data_o      (wr_data),
    .stop_o         (stop_pulse)
  );

  cfg_reg_bank #(.NUM_WR(NUM_WR), .DIV_LO_IDX(1)) u_bank (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_addr      (rd_addr),
    .rd_take      (rd_take),
    .rd_take_addr (rd_take_addr),
    .stop_i       (stop_pulse),
    .vas_ok_i     (vas_ok_i),
    .vas_idle_i   (vas_idle_i),
    .pll_lock_i   (pll_lock_i),
    .vco_band_i   (vco_band_i),
    .adc_code_i   (adc_code_i),
    .cfg_o        (cfg_regs_o),
    .rd_data_o    (rd_byte),
    .div_lo_wr_o  (div_lo_wr_o),
    .por_o        (por_flag)
  );

endmodule

// File: rtl/tuner_i2c_regs_chk.sv
module tuner_i2c_regs_chk #(
  parameter int unsigned NUM_WR = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   scl_i,
  input logic                   sda_oe_o,
  input logic                   wr_en,
  input logic [7:0]             wr_addr,
  input logic [7:0]             wr_data,
  input logic [NUM_WR-1:0][7:0] cfg_regs,
  input logic                   div_lo_wr_o,
  input logic                   por_flag,
  input logic                   stop_pulse
);

  localparam int unsigned IDX_W = $clog2(NUM_WR);

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);  // R5

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr < 8'(NUM_WR)) |=> (cfg_regs[$past(wr_addr[IDX_W-1:0])] == $past(wr_data)));  // R3

  AST_RO_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= 8'(NUM_WR)) |=> (cfg_regs == $past(cfg_regs)));  // R8

  AST_DIVLO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    div_lo_wr_o |=> !div_lo_wr_o);  // R10

  AST_DIVLO_CAUSE: assert property (@(posedge clk) disable iff (rst)
    div_lo_wr_o |-> $past(wr_en && wr_addr == 8'd1));  // R10

  AST_POR_SET_OUT_OF_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> por_flag);  // R9

  AST_POR_CLEARS_AT_STOP: assert property (@(posedge clk) disable iff (rst)
    $fell(por_flag) |-> $past(stop_pulse));  // R9

endmodule

bind tuner_i2c_regs tuner_i2c_regs_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .scl_i       (scl_i),
  .sda_oe_o    (sda_oe_o),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .cfg_regs    (cfg_regs_o),
  .div_lo_wr_o (div_lo_wr_o),
  .por_flag    (por_flag),
  .stop_pulse  (stop_pulse)
);

// File: tb/tb_tuner_i2c_regs.sv
module tb_tuner_i2c_regs;

  localparam int NW = 12;
  localparam int Q  = 8;   // quarter of a bus clock, in system clocks

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_oe;
  logic div_lo;
  logic [NW-1:0][7:0] cfg;
  wire  sda_line = sda_m & ~sda_oe;

  tuner_i2c_regs dut (
    .clk (clk), .rst (rst), .scl_i (scl_m), .sda_i (sda_line),
    .addr_sel_i (addr_sel), .vas_ok_i (1'b1), .vas_idle_i (1'b0),
    .pll_lock_i (1'b1), .vco_band_i (5'b10011), .adc_code_i (3'b101),
    .sda_oe_o (sda_oe), .cfg_regs_o (cfg), .div_lo_wr_o (div_lo)
  );

  int n_vec = 0, n_bad = 0;
  int div_hi = 0, exp_div = 0;
  logic [7:0] mdl [NW];
  logic por_m = 1'b1;

  always @(posedge clk) if (!rst && div_lo) div_hi <= div_hi + 1;

  function automatic logic [7:0] reset_val(input int i);
    case (i)
      0: return 8'h03; 1: return 8'hB6; 5: return 8'h04; 6: return 8'hC0;
      7: return 8'hCC; 8: return 8'h4B; default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    if (a < NW)       return mdl[a];
    else if (a == 12) return {por_m, 1'b1, 1'b0, 1'b1, 4'b0000};
    else if (a == 13) return 8'h9D;
    else              return 8'h00;
  endfunction

  function automatic logic [7:0] dev_byte(input logic pin, input logic rd);
    return {6'b110000, pin, rd};
  endfunction

  task automatic check(input logic [7:0] got, input logic [7:0] expv, input string what);
    n_vec++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", what, got, expv);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(Q); scl_m = 1'b1; qwait(Q);
    sda_m = 1'b0; qwait(Q); scl_m = 1'b0; qwait(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(Q); scl_m = 1'b1; qwait(Q);
    sda_m = 1'b1; qwait(2 * Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qwait(Q); scl_m = 1'b1; qwait(2 * Q); scl_m = 1'b0; qwait(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qwait(Q); scl_m = 1'b1; qwait(Q);
    b = sda_line; qwait(Q); scl_m = 1'b0; qwait(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~master_ack);
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < NW; i++)
      check(cfg[i], mdl[i], $sformatf("%s reg %0d", tag, i));
  endtask

  // Write burst; data taken from wbuf. Checks every acknowledge.
  logic [7:0] wbuf [8];
  task automatic wr_burst(input logic [7:0] dev, input int p, input int n,
                          input logic exp_ack, input string tag);
    logic a;
    bus_start();
    send_byte(dev, a);
    check({7'd0, a}, {7'd0, exp_ack}, {tag, " address ack (R1/R5)"});
    if (a) begin
      send_byte(8'(p), a);
      check({7'd0, a}, 8'd1, {tag, " pointer ack R5"});
      for (int i = 0; i < n; i++) begin
        send_byte(wbuf[i], a);
        check({7'd0, a}, 8'd1, {tag, " data ack R5"});
        if (p + i < NW) mdl[p + i] = wbuf[i];
        if (p + i == 1) exp_div++;
      end
    end
    bus_stop();
  endtask

  task automatic rd_burst(input int p, input int n, input string tag);
    logic a;
    logic [7:0] d;
    logic saw_st1;
    saw_st1 = 1'b0;
    bus_start();
    send_byte(dev_byte(addr_sel, 1'b0), a);
    check({7'd0, a}, 8'd1, {tag, " address ack R1"});
    send_byte(8'(p), a);
    check({7'd0, a}, 8'd1, {tag, " pointer ack R5"});
    bus_start();
    send_byte(dev_byte(addr_sel, 1'b1), a);
    check({7'd0, a}, 8'd1, {tag, " read address ack R2"});
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      check(d, exp_read(p + i), $sformatf("%s read ptr %0d (R4/R7/R8)", tag, p + i));
      if (p + i == 12) saw_st1 = 1'b1;
    end
    qwait(Q);
    check({7'd0, sda_oe}, 8'd0, {tag, " SDA released after NACK R4"});
    bus_stop();
    if (saw_st1) por_m = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic a;
    void'($urandom(32'd20571));
    for (int i = 0; i < NW; i++) mdl[i] = reset_val(i);
    repeat (10) @(negedge clk);
    rst = 1'b0;
    qwait(4);

    // R6: reset contents
    check_regs("R6 reset");
    check({7'd0, sda_oe}, 8'd0, "R5 idle SDA released");

    // R9: read 0x0D only, flag must survive; then read 0x0C and see it clear
    rd_burst(13, 1, "R9 status2 only");
    rd_burst(12, 2, "R9 status1 read");
    rd_burst(12, 1, "R9 flag cleared");

    // R3/R10: burst from pointer 0 touching the divider low byte
    for (int i = 0; i < 3; i++) wbuf[i] = 8'($urandom);
    wr_burst(dev_byte(1'b0, 1'b0), 0, 3, 1'b1, "R3 burst");
    check_regs("R3 after burst");

    // R1: wrong address with pin low
    wbuf[0] = 8'h5A;
    wr_burst(dev_byte(1'b1, 1'b0), 8, 1, 1'b0, "R1 pin0 addr C2");
    check_regs("R1 no change");
    addr_sel = 1'b1;
    wbuf[0] = 8'hA7;
    wr_burst(dev_byte(1'b1, 1'b0), 8, 1, 1'b1, "R1 pin1 addr C2");
    wbuf[0] = 8'h11;
    wr_burst(dev_byte(1'b0, 1'b0), 9, 1, 1'b0, "R1 pin1 addr C0");
    check_regs("R1 pin high");

    // R8: writes crossing into read-only space, read past the end
    for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
    wr_burst(dev_byte(addr_sel, 1'b0), 11, 4, 1'b1, "R8 ro write");
    check_regs("R8 after ro write");
    rd_burst(10, 6, "R8 read past end");

    // R2: repeated START in the middle of a write
    bus_start();
    send_byte(dev_byte(addr_sel, 1'b0), a);
    send_byte(8'd5, a);
    send_byte(8'h3C, a); mdl[5] = 8'h3C;
    bus_start();
    send_byte(dev_byte(addr_sel, 1'b0), a);
    check({7'd0, a}, 8'd1, "R2 address after repeated start");
    send_byte(8'd1, a);
    send_byte(8'hE4, a); mdl[1] = 8'hE4; exp_div++;
    bus_stop();
    check_regs("R2 repeated start");

    // Random bursts on both sides of the read-only boundary
    for (int it = 0; it < 10; it++) begin
      int p, n;
      p = int'($urandom_range(0, 13));
      n = int'($urandom_range(1, 4));
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_burst(dev_byte(addr_sel, 1'b0), p, n, 1'b1, "R3 random write");
      rd_burst(int'($urandom_range(0, 13)), int'($urandom_range(1, 4)), "R4 random read");
    end
    check_regs("R3 final");
    check(8'(div_hi), 8'(exp_div), "R10 divider low pulse cycles");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule